// File: doc/BRIEF.md
# LPC Host SYNC Phase Monitor

This block lives inside the host side of a Low Pin Count bus controller. The cycle sequencer asserts `start_i` at the clock edge just before the first SYNC nibble is due, giving the cycle kind and the direction. From the next edge on, the monitor samples the 4-bit LAD bus once per clock. It classifies each nibble, lets wait-state codes stretch the phase, and aborts when nothing answers or when a code is illegal. On reads it collects the two data nibbles that follow a terminating SYNC.

The outcome goes back to the sequencer as a one-clock `done_o` pulse with a 3-bit status code. Alongside it come the assembled byte, a flag marking a byte that came with an error SYNC, and two DMA channel hints: more transfers wanted, or request withdrawn.

The result leaves the block as a single-cycle report with no back-pressure. The sequencer cannot stall it and must take the values on the `done_o` cycle or later. Every result output holds its value until the next accepted start, and that start clears it to zero.

Top module: `lpc_sync_mon`

## Requirements
- R1: SYNC nibble codes are 0000 ready, 0101 short wait, 0110 long wait, 1001 ready-more, 1010 error, and 1111 bus idle (no driver). The status codes are 0 none, 1 ready, 2 ready-more, 3 error, 4 timeout and 5 invalid. On a write, a ready, error or ready-more code sampled at edge k gives `done_o` high for the clock after edge k.
- R2: Short and long wait codes extend the phase without aborting. Ten short waits in a row followed by ready complete as ready.
- R3: When the bus shows 1111 on each of the first NORESP_CLKS (4) SYNC clocks with no wait code seen yet, the cycle ends with status timeout after the fourth such clock. A valid code on the fourth clock still completes normally.
- R4: Any nibble other than the six listed in R1 ends the cycle with status invalid on the clock it is sampled, including after wait states.
- R5: Ready-more is accepted only when the cycle kind is DMA (`cyc_kind_i` = 10). On memory (00) or I/O (01) cycles it yields status invalid.
- R6: On a read, the two nibbles after a terminating SYNC form `data_o`, the first nibble in bits 3:0 and the second in bits 7:4. `done_o` pulses after the second nibble.
- R7: An error SYNC on a read still collects the data byte, reports status error and sets `data_err_o`. `data_err_o` is never set for other outcomes.
- R8: On DMA cycles, ready and error set `dma_stop_o`, and ready-more sets `dma_more_o`. Both stay 0 on non-DMA cycles.
- R9: Once a wait code has been seen, bus idle no longer times out. A watchdog of WDOG_CLKS SYNC clocks (0 disables it) ends any phase with status timeout on its last clock.
- R10: `done_o` is high for exactly one clock. The result outputs hold until the next accepted start, which clears them to zero.
- R11: `start_i` while a cycle is in progress is ignored; the cycle kind latched at start still governs decoding.
- R12: A synchronous active-high `rst` returns the block to idle with `busy_o`, `done_o` and every result output at 0, even mid-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of SYNC phase, accepted while idle |
| cyc_kind_i | input | 2 | 00 memory, 01 I/O, 10 DMA, 11 treated as memory |
| cyc_read_i | input | 1 | 1 for a read cycle |
| lad_i | input | 4 | LAD bus nibble |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock completion pulse |
| status_o | output | 3 | Outcome code per R1 |
| data_o | output | 8 | Byte collected on reads |
| data_err_o | output | 1 | Byte arrived with an error SYNC |
| dma_more_o | output | 1 | DMA channel wants more transfers |
| dma_stop_o | output | 1 | DMA request withdrawn |

## Verification
The bench builds the block with NORESP_CLKS = 4 and WDOG_CLKS = 40. A phase made only of long waits therefore hits the watchdog at clock 40, well inside the run. That keeps the watchdog path reachable while staying clearly apart from the four-clock no-response rule and from the ten-long run of short waits, which has to pass through untouched.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_SHORT = 4'b0101;
  localparam logic [3:0] NIB_LONG  = 4'b0110;
  localparam logic [3:0] NIB_MORE  = 4'b1001;
  localparam logic [3:0] NIB_ERROR = 4'b1010;
  localparam logic [3:0] NIB_IDLE  = 4'b1111;

  localparam logic [1:0] KIND_DMA = 2'b10;

  typedef enum logic [2:0] {
    SC_READY, SC_SHORT, SC_LONG, SC_MORE, SC_ERR, SC_IDLE, SC_BAD
  } sync_cls_e;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_READY   = 3'd1,
    RES_MORE    = 3'd2,
    RES_ERROR   = 3'd3,
    RES_TIMEOUT = 3'd4,
    RES_INVALID = 3'd5
  } res_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DLO, ST_DHI} mon_st_e;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
  import lpc_sync_pkg::*;
(
  input  logic [3:0] nib_i,
  input  logic       dma_i,
  output sync_cls_e  cls_o
);

  always_comb begin
    unique case (nib_i)
      NIB_READY: cls_o = SC_READY;
      NIB_SHORT: cls_o = SC_SHORT;
      NIB_LONG:  cls_o = SC_LONG;
      NIB_MORE:  cls_o = dma_i ? SC_MORE : SC_BAD;
      NIB_ERROR: cls_o = SC_ERR;
      NIB_IDLE:  cls_o = SC_IDLE;
      default:   cls_o = SC_BAD;
    endcase
  end

endmodule

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
  parameter int NORESP_CLKS = 4,
  parameter int WDOG_CLKS   = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic idle_i,
  input  logic waited_i,
  output logic noresp_hit_o,
  output logic wdog_hit_o
);

  localparam int NR_W = (NORESP_CLKS > 1) ? $clog2(NORESP_CLKS) : 1;
  localparam int WD_W = (WDOG_CLKS > 1) ? $clog2(WDOG_CLKS) : 1;

  logic [NR_W-1:0] nr_q;

  assign noresp_hit_o = run_i && idle_i && !waited_i &&
                        (nr_q == NR_W'(NORESP_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      nr_q <= '0;
    end else if (run_i && idle_i && !waited_i && !noresp_hit_o) begin
      nr_q <= nr_q + 1'b1;
    end
  end

  generate
    if (WDOG_CLKS > 0) begin : g_wd
      logic [WD_W-1:0] wd_q;
      assign wdog_hit_o = run_i && (wd_q == WD_W'(WDOG_CLKS - 1));
      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          wd_q <= '0;
        end else if (run_i && !wdog_hit_o) begin
          wd_q <= wd_q + 1'b1;
        end
      end
    end else begin : g_nowd
      assign wdog_hit_o = 1'b0;
    end
  endgenerate

  // R3
  nr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(nr_q) < NORESP_CLKS);

endmodule

// File: rtl/lpc_sync_capture.sv
module lpc_sync_capture (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_i,
  input  logic       lo_en_i,
  input  logic [3:0] nib_i,
  output logic [7:0] byte_o
);

  logic [3:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) lo_q <= '0;
    else if (lo_en_i)   lo_q <= nib_i;
  end

  assign byte_o = {nib_i, lo_q};

endmodule

// File: rtl/lpc_sync_mon.sv
module lpc_sync_mon
  import lpc_sync_pkg::*;
#(
  parameter int NORESP_CLKS = 4,
  parameter int WDOG_CLKS   = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] cyc_kind_i,
  input  logic       cyc_read_i,
  input  logic [3:0] lad_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] status_o,
  output logic [7:0] data_o,
  output logic       data_err_o,
  output logic       dma_more_o,
  output logic       dma_stop_o
);

  mon_st_e   st_q;
  logic [1:0] kind_q;
  logic      rd_q;
  logic      waited_q;
  res_e      pend_q;
  sync_cls_e cls;
  logic      accept;
  logic      noresp_hit, wdog_hit;
  logic [7:0] byte_w;
  logic      fin, go_data;
  res_e      fin_code, pend_n;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign busy_o = (st_q != ST_IDLE);

  lpc_sync_decode u_dec (
    .nib_i (lad_i),
    .dma_i (kind_q == KIND_DMA),
    .cls_o (cls)
  );

  lpc_sync_timer #(
    .NORESP_CLKS (NORESP_CLKS),
    .WDOG_CLKS   (WDOG_CLKS)
  ) u_tmr (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (accept),
    .run_i        (st_q == ST_SYNC),
    .idle_i       (cls == SC_IDLE),
    .waited_i     (waited_q),
    .noresp_hit_o (noresp_hit),
    .wdog_hit_o   (wdog_hit)
  );

  lpc_sync_capture u_cap (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .lo_en_i (st_q == ST_DLO),
    .nib_i   (lad_i),
    .byte_o  (byte_w)
  );

  function automatic res_e term_code(input sync_cls_e c);
    unique case (c)
      SC_MORE: return RES_MORE;
      SC_ERR:  return RES_ERROR;
      default: return RES_READY;
    endcase
  endfunction

  always_comb begin
    fin      = 1'b0;
    fin_code = RES_NONE;
    go_data  = 1'b0;
    pend_n   = pend_q;
    unique case (st_q)
      ST_SYNC: begin
        unique case (cls)
          SC_READY, SC_ERR, SC_MORE: begin
            if (rd_q) begin
              go_data = 1'b1;
              pend_n  = term_code(cls);
            end else begin
              fin      = 1'b1;
              fin_code = term_code(cls);
            end
          end
          SC_SHORT, SC_LONG: begin
            if (wdog_hit) begin
              fin      = 1'b1;
              fin_code = RES_TIMEOUT;
            end
          end
          SC_IDLE: begin
            if (noresp_hit || wdog_hit) begin
              fin      = 1'b1;
              fin_code = RES_TIMEOUT;
            end
          end
          default: begin
            fin      = 1'b1;
            fin_code = RES_INVALID;
          end
        endcase
      end
      ST_DHI: begin
        fin      = 1'b1;
        fin_code = pend_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      kind_q     <= '0;
      rd_q       <= 1'b0;
      waited_q   <= 1'b0;
      pend_q     <= RES_NONE;
      done_o     <= 1'b0;
      status_o   <= '0;
      data_o     <= '0;
      data_err_o <= 1'b0;
      dma_more_o <= 1'b0;
      dma_stop_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      pend_q <= pend_n;
      if (accept) begin
        st_q       <= ST_SYNC;
        kind_q     <= cyc_kind_i;
        rd_q       <= cyc_read_i;
        waited_q   <= 1'b0;
        status_o   <= '0;
        data_o     <= '0;
        data_err_o <= 1'b0;
        dma_more_o <= 1'b0;
        dma_stop_o <= 1'b0;
      end else if (fin) begin
        st_q       <= ST_IDLE;
        done_o     <= 1'b1;
        status_o   <= fin_code;
        data_o     <= (st_q == ST_DHI) ? byte_w : 8'h00;
        data_err_o <= (st_q == ST_DHI) && (fin_code == RES_ERROR);
        dma_more_o <= (fin_code == RES_MORE);
        dma_stop_o <= (kind_q == KIND_DMA) &&
                      ((fin_code == RES_READY) || (fin_code == RES_ERROR));
      end else begin
        if (go_data) st_q <= ST_DLO;
        else if (st_q == ST_DLO) st_q <= ST_DHI;
        if (st_q == ST_SYNC && (cls == SC_SHORT || cls == SC_LONG))
          waited_q <= 1'b1;
      end
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R1
  done_status_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (status_o != 3'd0));

  // R5
  more_dma_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == 3'd2) |-> (kind_q == KIND_DMA));

  // R7
  derr_chk: assert property (@(posedge clk) disable iff (rst)
    data_err_o |-> (status_o == 3'd3 && rd_q));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(kind_q));

endmodule

// File: tb/lpc_sync_mon_tb.sv
module lpc_sync_mon_tb_top;

  localparam int PER  = 10;
  localparam int MAXE = 64;

  typedef struct packed {
    logic [1:0]  kind;
    logic        rd;
    logic [63:0] nibs;
    logic [6:0]  edge_n;
    logic [2:0]  st;
    logic [7:0]  data;
    logic        derr;
    logic        more;
    logic        stop;
  } vec_t;

  localparam int NV = 15;
  // nibble 0 (first SYNC clock) is the rightmost hex digit
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 7'd1,  3'd1, 8'h00, 1'b0, 1'b0, 1'b0}, // R1
    '{2'b00, 1'b1, 64'hFFFF_FFFF_FFFA_3055, 7'd5,  3'd1, 8'hA3, 1'b0, 1'b0, 1'b0}, // R6
    '{2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FC5A, 7'd3,  3'd3, 8'hC5, 1'b1, 1'b0, 1'b0}, // R7
    '{2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_F219, 7'd3,  3'd2, 8'h21, 1'b0, 1'b1, 1'b0}, // R8
    '{2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFA, 7'd1,  3'd3, 8'h00, 1'b0, 1'b0, 1'b1}, // R8
    '{2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 7'd1,  3'd5, 8'h00, 1'b0, 1'b0, 1'b0}, // R5
    '{2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFF3, 7'd1,  3'd5, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    '{2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 7'd4,  3'd4, 8'h00, 1'b0, 1'b0, 1'b0}, // R3
    '{2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_0FFF, 7'd4,  3'd1, 8'h00, 1'b0, 1'b0, 1'b0}, // R3
    '{2'b01, 1'b0, 64'hFFFF_FFFF_FFF0_FFFF, 7'd4,  3'd4, 8'h00, 1'b0, 1'b0, 1'b0}, // R3
    '{2'b00, 1'b0, 64'hFFFF_FFFF_F0FF_FFF6, 7'd7,  3'd1, 8'h00, 1'b0, 1'b0, 1'b0}, // R9
    '{2'b01, 1'b0, 64'hFFFF_F055_5555_5555, 7'd11, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
    '{2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FF05, 7'd2,  3'd1, 8'h00, 1'b0, 1'b0, 1'b1}, // R2
    '{2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FC55, 7'd3,  3'd5, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    '{2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_FF0A, 7'd3,  3'd3, 8'hF0, 1'b1, 1'b0, 1'b1}  // R7
  };
  localparam string VREQ [NV] = '{"R1", "R6", "R7", "R8", "R8", "R5", "R4",
                                  "R3", "R3", "R3", "R9", "R2", "R2", "R4", "R7"};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] cyc_kind_i = 2'b00;
  logic       cyc_read_i = 1'b0;
  logic [3:0] lad_i = 4'hF;
  logic       busy_o, done_o, data_err_o, dma_more_o, dma_stop_o;
  logic [2:0] status_o;
  logic [7:0] data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PER/2) clk = ~clk;

  lpc_sync_mon #(.NORESP_CLKS(4), .WDOG_CLKS(40)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cyc_kind_i(cyc_kind_i),
    .cyc_read_i(cyc_read_i), .lad_i(lad_i), .busy_o(busy_o), .done_o(done_o),
    .status_o(status_o), .data_o(data_o), .data_err_o(data_err_o),
    .dma_more_o(dma_more_o), .dma_stop_o(dma_stop_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic [1:0] kind, input logic rd,
                         input logic [63:0] nibs, input logic [3:0] fill,
                         input int exp_edge, input logic [2:0] st,
                         input logic [7:0] data, input logic derr,
                         input logic more, input logic stop, input string req);
    int got = 0;
    @(negedge clk);
    start_i = 1'b1; cyc_kind_i = kind; cyc_read_i = rd; lad_i = 4'hF;
    @(posedge clk); #(PER/4);
    chk(status_o == 3'd0 && busy_o, "R10", "cleared on start", {busy_o, status_o}, 4'h8);
    for (int e = 1; e <= MAXE && got == 0; e++) begin
      @(negedge clk);
      start_i = 1'b0;
      lad_i = (e <= 16) ? nibs[4*(e-1) +: 4] : fill;
      @(posedge clk); #(PER/4);
      if (done_o) got = e;
    end
    chk(got == exp_edge, req, "done clock", got, exp_edge);
    chk(status_o == st, req, "status", status_o, st);
    chk(data_o == data, req, "data", data_o, data);
    chk({data_err_o, dma_more_o, dma_stop_o} == {derr, more, stop}, req,
        "err/more/stop", {data_err_o, dma_more_o, dma_stop_o}, {derr, more, stop});
    @(negedge clk); lad_i = 4'hF;
    @(posedge clk); #(PER/4);
    chk(!done_o && status_o == st, "R10", "pulse ends, result held",
        {done_o, status_o}, {1'b0, st});
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected done", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PER/4);
    // R12 reset state
    chk({busy_o, done_o, status_o, data_o, data_err_o, dma_more_o, dma_stop_o} == '0,
        "R12", "reset outputs", {busy_o, done_o, status_o}, 0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_seq(VECS[i].kind, VECS[i].rd, VECS[i].nibs, 4'hF, int'(VECS[i].edge_n),
              VECS[i].st, VECS[i].data, VECS[i].derr, VECS[i].more, VECS[i].stop,
              VREQ[i]);
    end

    // R9 watchdog on endless long waits
    run_seq(2'b01, 1'b0, {16{4'h6}}, 4'h6, 40, 3'd4, 8'h00, 1'b0, 1'b0, 1'b0, "R9");

    // R11 start while busy ignored: I/O cycle stays I/O, ready-more is invalid
    @(negedge clk); start_i = 1'b1; cyc_kind_i = 2'b01; cyc_read_i = 1'b0;
    @(posedge clk);
    @(negedge clk); start_i = 1'b0; lad_i = 4'h6;
    @(posedge clk);
    @(negedge clk); start_i = 1'b1; cyc_kind_i = 2'b10; lad_i = 4'h6;
    @(posedge clk);
    @(negedge clk); start_i = 1'b0; lad_i = 4'h9;
    @(posedge clk); #(PER/4);
    chk(done_o && status_o == 3'd5 && !dma_more_o, "R11", "busy start ignored",
        {done_o, status_o}, 4'hD);
    @(negedge clk); lad_i = 4'hF;

    // R12 reset mid-cycle
    @(negedge clk); start_i = 1'b1; cyc_kind_i = 2'b10; cyc_read_i = 1'b1;
    @(posedge clk);
    @(negedge clk); start_i = 1'b0; lad_i = 4'h5;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #(PER/4);
    chk(!busy_o && !done_o && status_o == 3'd0, "R12", "mid-cycle reset",
        {busy_o, done_o, status_o}, 0);
    @(negedge clk); rst = 1'b0; lad_i = 4'hF;
    repeat (3) @(posedge clk); #(PER/4);
    chk(!busy_o && !done_o, "R12", "stays idle", {busy_o, done_o}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule